// File: doc/BRIEF.md
# Indexed Register and Memory Window

This block places a two-location access port in front of a much larger address space. The first location holds a 32-bit pointer. The second location is a four-byte data aperture. Any access to the aperture is carried out at the place the pointer names.

When the pointer's top bit is set, the access goes to video memory. When it is clear, the access goes to the register space. The host can therefore reach every register and every byte of memory through two small locations.

Memory accesses are checked against the configured memory size. A pointer that aims back at the aperture itself, or at anything below it, is refused. Downstream accesses use a request/acknowledge handshake. The host sees one acknowledge pulse per accepted access, and it issues its next access only after that pulse.

Top module: `regwin_bridge`

## Requirements
- R1: A write to host offsets 0..3 (host_addr bit 2 = 0), of any size, stores host_wdata into the pointer with bits [1:0] forced to 0. A read there returns the stored pointer.
- R2: After reset the pointer is 0, and host_ack, host_err, reg_req and mem_req are all low.
- R3: With pointer bit 31 set, an aperture access (host_addr bit 2 = 1) becomes one memory request at byte address pointer[30:0], whatever the aperture offset.
  - Data is little-endian and right-aligned: value byte i travels in lane i.
  - mem_be has one bit per lane for the low 1, 2 or 4 lanes.
- R4: A memory access is issued only if pointer[30:0] <= MEM_BYTES − access bytes. Otherwise no request is made, a write is dropped, a read returns 0, and host_err stays low.
- R5: With bit 31 clear and pointer > DATA_BASE+3, the access becomes a register request at pointer + host_addr[1:0], with the normalised size code.
- R6: With bit 31 clear and pointer <= DATA_BASE+3, nothing is issued. A read returns 0, and host_err pulses for exactly one cycle, together with host_ack.
- R7: Size codes are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes; code 3 is treated as 4 bytes and forwarded as 2. All four aperture offsets accept all sizes. Returned read data is zero above the access size.
- R8: A downstream request holds its fields stable until its acknowledge. host_ack rises the cycle after that acknowledge is sampled, and carries the returned data.
- R9: Pointer accesses, rejected accesses and out-of-range memory accesses complete with host_ack in the cycle after host_req.
- R10: A host_req that arrives while a downstream access is outstanding is ignored. It neither changes the pointer nor produces an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | One-cycle access strobe |
| host_we | input | 1 | 1 = write |
| host_addr | input | 3 | Bit 2 selects aperture; bits 1:0 byte offset |
| host_size | input | 2 | Access size code |
| host_wdata | input | 32 | Right-aligned write value |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read value, valid with host_ack |
| host_err | output | 1 | One-cycle rejection pulse |
| reg_req | output | 1 | Register request, held until reg_ack |
| reg_we | output | 1 | Register write |
| reg_addr | output | 32 | Register byte address |
| reg_size | output | 2 | Register size code |
| reg_wdata | output | 32 | Register write value |
| reg_ack | input | 1 | Register acknowledge |
| reg_rdata | input | 32 | Register read value |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory write |
| mem_addr | output | MEM_AW | Memory byte address |
| mem_be | output | 4 | Memory byte-lane enables |
| mem_wdata | output | 32 | Memory write value |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read value |

## Verification
The aperture is tried with pointers in each of its four decode classes:
- in-range memory;
- out-of-range memory just past the last legal byte;
- forwarded register, at the first pointer above the aperture;
- refused register, at the aperture base and at zero.

These pointers tell the decode boundaries apart. Sub-word accesses at offsets 0 to 3 use sizes 1, 2 and the reserved code. They separate an offset that must be added (register mode) from one that must be ignored (memory mode), and they show read masking. A stray strobe during an outstanding access shows that busy-time requests are dropped.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_REG  = 2'd1,
        PH_MEM  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        K_MEM     = 2'd0,
        K_MEM_OOB = 2'd1,
        K_REG     = 2'd2,
        K_REJECT  = 2'd3
    } kind_e;

    // byte count of a size code; code 3 behaves as a word
    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [1:0] size_norm(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
    import regwin_pkg::*;
#(
    parameter logic [31:0] DATA_BASE = 32'h4,
    parameter int          MEM_BYTES = 1 << 20,
    parameter int          MEM_AW    = $clog2(MEM_BYTES)
) (
    input  logic [31:0]       ptr,
    input  logic [1:0]        offset,
    input  logic [1:0]        size_code,
    output kind_e             kind,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [31:0]       reg_addr
);
    localparam logic [31:0] WIN_LAST = DATA_BASE + 32'd3;
    localparam logic [32:0] MEM_LIM  = 33'(MEM_BYTES);

    logic [32:0] mem_off;
    logic [32:0] mem_room;

    always_comb begin
        mem_off  = {2'b00, ptr[30:0]};
        mem_room = MEM_LIM - 33'(size_bytes(size_code));
        mem_addr = ptr[MEM_AW-1:0];
        reg_addr = ptr + {30'd0, offset};
        if (ptr[31]) begin
            kind = (mem_off <= mem_room) ? K_MEM : K_MEM_OOB;
        end else if (ptr > WIN_LAST) begin
            kind = K_REG;
        end else begin
            kind = K_REJECT;
        end
    end
endmodule

// File: rtl/regwin_lanes.sv
module regwin_lanes
    import regwin_pkg::*;
#(
    parameter int BYTES = 4,
    localparam int W = BYTES * 8
) (
    input  logic [1:0]       size_code,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout,
    output logic [BYTES-1:0] be
);
    logic [2:0] nb;
    assign nb = size_bytes(size_code);

    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        assign be[i]            = (3'(i) < nb);
        assign dout[i*8 +: 8]   = be[i] ? din[i*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
    import regwin_pkg::*;
#(
    parameter logic [31:0] DATA_BASE = 32'h4,
    parameter int          MEM_BYTES = 1 << 20,
    parameter int          MEM_AW    = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [2:0]        host_addr,
    input  logic [1:0]        host_size,
    input  logic [31:0]       host_wdata,
    output logic              host_ack,
    output logic [31:0]       host_rdata,
    output logic              host_err,
    output logic              reg_req,
    output logic              reg_we,
    output logic [31:0]       reg_addr,
    output logic [1:0]        reg_size,
    output logic [31:0]       reg_wdata,
    input  logic              reg_ack,
    input  logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata
);
    localparam logic [32:0] MEM_LIM = 33'(MEM_BYTES);

    typedef struct packed {
        phase_e      phase;
        logic [31:0] ptr;
        logic        ack;
        logic        err;
        logic [31:0] rdata;
        logic        req;
        logic        we;
        logic [31:0] addr;
        logic [1:0]  size;
        logic [3:0]  be;
        logic [31:0] wdata;
    } win_state_t;

    win_state_t q, d;

    kind_e             kind;
    logic [MEM_AW-1:0] dec_mem_addr;
    logic [31:0]       dec_reg_addr;
    logic [31:0]       wdata_masked;
    logic [3:0]        wr_be;
    logic [31:0]       rd_raw;
    logic [31:0]       rd_masked;
    logic [3:0]        rd_be_unused;
    logic              down_ack;

    regwin_decode #(
        .DATA_BASE(DATA_BASE),
        .MEM_BYTES(MEM_BYTES),
        .MEM_AW   (MEM_AW)
    ) u_decode (
        .ptr      (q.ptr),
        .offset   (host_addr[1:0]),
        .size_code(host_size),
        .kind     (kind),
        .mem_addr (dec_mem_addr),
        .reg_addr (dec_reg_addr)
    );

    regwin_lanes #(.BYTES(4)) u_wr_lanes (
        .size_code(host_size),
        .din      (host_wdata),
        .dout     (wdata_masked),
        .be       (wr_be)
    );

    assign rd_raw   = (q.phase == PH_MEM) ? mem_rdata : reg_rdata;
    assign down_ack = (q.phase == PH_MEM) ? mem_ack : reg_ack;

    regwin_lanes #(.BYTES(4)) u_rd_lanes (
        .size_code(q.size),
        .din      (rd_raw),
        .dout     (rd_masked),
        .be       (rd_be_unused)
    );

    always_comb begin
        d     = q;
        d.ack = 1'b0;
        d.err = 1'b0;
        case (q.phase)
            PH_IDLE: begin
                if (host_req) begin
                    d.we    = host_we;
                    d.size  = size_norm(host_size);
                    d.wdata = wdata_masked;
                    d.be    = wr_be;
                    if (!host_addr[2]) begin
                        if (host_we) d.ptr = {host_wdata[31:2], 2'b00};
                        d.rdata = host_we ? 32'd0 : q.ptr;
                        d.ack   = 1'b1;
                    end else begin
                        case (kind)
                            K_MEM: begin
                                d.phase = PH_MEM;
                                d.req   = 1'b1;
                                d.addr  = 32'(dec_mem_addr);
                            end
                            K_REG: begin
                                d.phase = PH_REG;
                                d.req   = 1'b1;
                                d.addr  = dec_reg_addr;
                            end
                            K_MEM_OOB: begin
                                d.rdata = 32'd0;
                                d.ack   = 1'b1;
                            end
                            default: begin
                                d.rdata = 32'd0;
                                d.ack   = 1'b1;
                                d.err   = 1'b1;
                            end
                        endcase
                    end
                end
            end
            default: begin
                if (down_ack) begin
                    d.phase = PH_IDLE;
                    d.req   = 1'b0;
                    d.ack   = 1'b1;
                    d.rdata = q.we ? 32'd0 : rd_masked;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign host_ack   = q.ack;
    assign host_err   = q.err;
    assign host_rdata = q.rdata;

    assign reg_req   = q.req && (q.phase == PH_REG);
    assign reg_we    = q.we;
    assign reg_addr  = q.addr;
    assign reg_size  = q.size;
    assign reg_wdata = q.wdata;

    assign mem_req   = q.req && (q.phase == PH_MEM);
    assign mem_we    = q.we;
    assign mem_addr  = q.addr[MEM_AW-1:0];
    assign mem_be    = q.be;
    assign mem_wdata = q.wdata;

    // R6: the rejection pulse only ever accompanies a completion
    p_err_with_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |-> host_ack);

    // R6: the rejection pulse lasts a single cycle
    p_err_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |=> !host_err);

    // R8: a register request stays up with stable fields until acknowledged
    p_reg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_wdata)));

    // R8: a memory request stays up with stable fields until acknowledged
    p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_be)));

    // R4: an issued memory access never reaches beyond the memory
    p_mem_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((33'(mem_addr) + 33'($countones(mem_be))) <= MEM_LIM));

    // R3: memory lanes are a contiguous run from lane 0
    p_mem_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_be == 4'h1 || mem_be == 4'h3 || mem_be == 4'hF));

    // R8: at most one downstream request at a time
    p_one_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_req && mem_req));

    // R8: completion of a forwarded access follows its acknowledge
    p_ack_after_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_req && reg_ack) || (mem_req && mem_ack)) |=> host_ack);

endmodule

// File: tb/regwin_bridge_tb_top.sv
module regwin_bridge_tb_top;
    localparam int MB = 256;
    localparam int AW = $clog2(MB);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        host_req = 1'b0, host_we = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ack, host_err;
    logic [31:0] host_rdata;
    logic        reg_req, reg_we, reg_ack = 1'b0;
    logic [31:0] reg_addr, reg_wdata, reg_rdata = '0;
    logic [1:0]  reg_size;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata, mem_rdata = '0;

    regwin_bridge #(.DATA_BASE(32'h4), .MEM_BYTES(MB)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_size(host_size), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_rdata(host_rdata), .host_err(host_err),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_size(reg_size), .reg_wdata(reg_wdata),
        .reg_ack(reg_ack), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] rd;
        logic        err;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    logic [7:0]  mem_m [MB];
    int          reg_hits = 0, mem_hits = 0;
    logic [31:0] last_reg_addr = '0, last_reg_wdata = '0;
    logic [1:0]  last_reg_size = '0;
    logic        last_reg_we = 1'b0;

    function automatic logic [31:0] reg_pattern(logic [31:0] a);
        return {a[15:0], 16'hC3E1} ^ 32'h5A5A0000;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // register-side responder: acknowledge two cycles after the request is seen
    initial begin
        forever begin
            @(negedge clk);
            if (reg_req) begin
                repeat (2) @(negedge clk);
                reg_hits++;
                last_reg_addr  = reg_addr;
                last_reg_size  = reg_size;
                last_reg_we    = reg_we;
                last_reg_wdata = reg_wdata;
                reg_rdata = reg_pattern(reg_addr);
                reg_ack = 1'b1;
                @(negedge clk);
                reg_ack = 1'b0;
            end
        end
    end

    // memory-side responder
    initial begin
        for (int i = 0; i < MB; i++) mem_m[i] = 8'h00;
        forever begin
            @(negedge clk);
            if (mem_req) begin
                repeat (2) @(negedge clk);
                mem_hits++;
                for (int i = 0; i < 4; i++) begin
                    if (mem_we && mem_be[i] && (int'(mem_addr) + i < MB))
                        mem_m[int'(mem_addr) + i] = mem_wdata[i*8 +: 8];
                    mem_rdata[i*8 +: 8] = (int'(mem_addr) + i < MB) ? mem_m[int'(mem_addr) + i] : 8'h00;
                end
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
            end
        end
    end

    // monitor: every completion is compared with the oldest expected item
    initial begin
        forever begin
            @(negedge clk);
            if (host_ack) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R10 unexpected ack actual=1 expected=0");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check({e.tag, " rdata"}, host_rdata, e.rd);
                    check({e.tag, " err"}, {31'd0, host_err}, {31'd0, e.err});
                end
            end
        end
    end

    // drives one access, returns the number of cycles to completion
    task automatic access(input logic we, input logic [2:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, input logic [31:0] exp_rd,
                          input logic exp_err, input string tag, output int lat);
        exp_t e;
        e.rd = exp_rd; e.err = exp_err; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_size = sz; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        lat = 1;
        while (!host_ack && lat < 50) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic set_ptr(input logic [31:0] v);
        int l;
        access(1'b1, 3'd0, 2'd2, v, 32'd0, 1'b0, "R1 ptr write", l);
    endtask

    initial begin
        int lat;
        int hits0;
        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2 host_ack", {31'd0, host_ack}, 32'd0);
        check("R2 host_err", {31'd0, host_err}, 32'd0);
        check("R2 reg_req", {31'd0, reg_req}, 32'd0);
        check("R2 mem_req", {31'd0, mem_req}, 32'd0);
        rst_n = 1'b1;
        access(1'b0, 3'd0, 2'd2, 32'd0, 32'd0, 1'b0, "R2 ptr after reset", lat);
        check("R9 ptr read latency", lat, 1);

        // R1: low bits forced to zero
        access(1'b1, 3'd2, 2'd0, 32'h1234_5677, 32'd0, 1'b0, "R1 ptr write", lat);
        check("R9 ptr write latency", lat, 1);
        access(1'b0, 3'd0, 2'd2, 32'd0, 32'h1234_5674, 1'b0, "R1 ptr read", lat);

        // R3/R7: memory mode, offset ignored, lanes
        set_ptr(32'h8000_0010);
        hits0 = mem_hits;
        access(1'b1, 3'd4, 2'd2, 32'hDDCC_BBAA, 32'd0, 1'b0, "R3 mem word write", lat);
        check("R8 mem latency", lat, 4);
        access(1'b1, 3'd6, 2'd0, 32'hFFFF_FF11, 32'd0, 1'b0, "R7 mem byte write off2", lat);
        access(1'b0, 3'd5, 2'd2, 32'd0, 32'hDDCC_BB11, 1'b0, "R3 mem word read", lat);
        access(1'b0, 3'd7, 2'd1, 32'd0, 32'h0000_BB11, 1'b0, "R7 mem half read off3", lat);
        access(1'b0, 3'd4, 2'd3, 32'd0, 32'hDDCC_BB11, 1'b0, "R7 mem size3 read", lat);
        check("R3 mem hits", mem_hits - hits0, 5);
        check("R3 mem byte stored", {24'd0, mem_m[16]}, 32'h11);
        check("R3 mem byte kept", {24'd0, mem_m[17]}, 32'hBB);

        // R4: last legal word and first illegal byte
        set_ptr(32'h8000_00FC);
        access(1'b1, 3'd4, 2'd2, 32'h0102_0304, 32'd0, 1'b0, "R4 mem edge write", lat);
        access(1'b0, 3'd4, 2'd2, 32'd0, 32'h0102_0304, 1'b0, "R4 mem edge read", lat);
        set_ptr(32'h8000_0100);
        hits0 = mem_hits;
        access(1'b1, 3'd4, 2'd0, 32'h0000_00EE, 32'd0, 1'b0, "R4 oob write", lat);
        check("R9 oob latency", lat, 1);
        access(1'b0, 3'd4, 2'd0, 32'd0, 32'd0, 1'b0, "R4 oob read", lat);
        set_ptr(32'h8FFF_FFF0);
        access(1'b0, 3'd4, 2'd2, 32'd0, 32'd0, 1'b0, "R4 far oob read", lat);
        check("R4 oob no request", mem_hits - hits0, 0);

        // R5/R7: register forwarding with offset
        set_ptr(32'h0000_0100);
        access(1'b0, 3'd6, 2'd1, 32'd0, reg_pattern(32'h102) & 32'h0000_FFFF, 1'b0, "R5 reg half read", lat);
        check("R8 reg latency", lat, 4);
        check("R5 reg addr", last_reg_addr, 32'h102);
        check("R5 reg size", {30'd0, last_reg_size}, 32'd1);
        access(1'b1, 3'd5, 2'd0, 32'hFFFF_FFAB, 32'd0, 1'b0, "R5 reg byte write", lat);
        check("R5 reg waddr", last_reg_addr, 32'h101);
        check("R5 reg wdata", last_reg_wdata, 32'h0000_00AB);
        check("R5 reg we", {31'd0, last_reg_we}, 32'd1);
        access(1'b0, 3'd4, 2'd3, 32'd0, reg_pattern(32'h100), 1'b0, "R7 reg size3 read", lat);
        check("R7 size3 forwarded", {30'd0, last_reg_size}, 32'd2);
        set_ptr(32'h0000_0008);
        access(1'b0, 3'd7, 2'd0, 32'd0, reg_pattern(32'hB) & 32'hFF, 1'b0, "R5 first legal ptr", lat);
        check("R5 boundary addr", last_reg_addr, 32'hB);

        // R6: refused pointers
        set_ptr(32'h0000_0004);
        hits0 = reg_hits;
        access(1'b0, 3'd4, 2'd2, 32'd0, 32'd0, 1'b1, "R6 reject at base", lat);
        check("R9 reject latency", lat, 1);
        set_ptr(32'h0000_0000);
        access(1'b1, 3'd6, 2'd1, 32'h1234, 32'd0, 1'b1, "R6 reject write", lat);
        check("R6 nothing issued", reg_hits - hits0, 0);
        @(negedge clk);
        check("R6 err one cycle", {31'd0, host_err}, 32'd0);

        // R10: strobe during an outstanding register access
        set_ptr(32'h0000_0200);
        begin
            exp_t e;
            e.rd = reg_pattern(32'h200); e.err = 1'b0; e.tag = "R10 outstanding read";
            exp_q.push_back(e);
            @(negedge clk);
            host_req = 1'b1; host_we = 1'b0; host_addr = 3'd4; host_size = 2'd2;
            @(negedge clk);
            host_we = 1'b1; host_addr = 3'd0; host_wdata = 32'hCAFE_0000;
            @(negedge clk);
            host_req = 1'b0;
            lat = 0;
            while (!host_ack && lat < 50) begin
                @(negedge clk);
                lat++;
            end
        end
        access(1'b0, 3'd0, 2'd2, 32'd0, 32'h0000_0200, 1'b0, "R10 ptr unchanged", lat);

        repeat (4) @(negedge clk);
        check("R8 all completions seen", exp_q.size(), 0);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule